// File: doc/BRIEF.md
# Serial Transmitter with Single-Frame and Held Line Break

This block is a serial transmitter for asynchronous links. It sends frames of one low start bit, then 8 or 9 data bits least significant bit first, then 1 or 2 high stop bits. A single-cycle baud tick from outside sets the bit rate, and every bit period lasts from one tick to the next. A one-entry holding register accepts a byte while the previous frame is still being shifted out, so frames can be sent back to back.

The transmitter can also produce a break on the line in two ways. A one-shot request makes one frame of all zeros followed by the normal stop bits, and the hardware clears the request by itself. The request waits behind a character that is already on the line, and software can withdraw it before the break frame begins. A level-held break drives the line low for as long as its input stays high. This supports breaks far longer than a frame, such as the multi-second low periods some protocols on single-wire buses need. When the held break is released, a guard interval keeps the line high before anything else is sent.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, tx is high, busy, tx_done and brk_req are low, wr_ready is high, and tx stays high whenever busy is low.
- R2: A data frame is one low start bit, then the data bits least significant bit first (8 bits when cfg_nine=0, 9 bits when cfg_nine=1), then one high stop bit (cfg_two_stop=0) or two (cfg_two_stop=1). Each bit lasts one baud-tick period, and the frame begins at the first baud tick after the byte is available.
- R3: A one-shot break frame holds tx low for 1+N bit periods, where N is the configured number of data bits. It then drives the configured 1 or 2 stop bits high.
- R4: A one-shot break requested while a data frame is being sent starts right after that frame's last stop bit. The data frame is sent unchanged.
- R5: The hardware clears brk_req when the break frame enters its first stop bit. At that moment tx is high and busy is still high.
- R6: If brk_req_clr is pulsed before the break frame has started, no break is sent and tx stays high.
- R7: A brk_req_set pulse that arrives while a break frame (low part or stop bits) is in progress is ignored. A pulse that arrives after that frame has ended produces a new break.
- R8: While brk_hold is high, tx is low from the next clock on, whatever frame was in progress. The frame that was being sent is abandoned.
- R9: After brk_hold falls, tx stays high and the transmitter leaves the guard interval on the second baud tick. The next start bit therefore follows at least one full bit period of high line.
- R10: wr_ready is low while brk_hold is high, while a one-shot request is pending, and during a break frame or guard interval. A byte queued before a held break is sent after the guard interval.
- R11: busy is high during any frame, held break or guard interval. tx_done pulses for exactly one cycle each time the line returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cfg_nine | input | 1 | 1: nine data bits, 0: eight |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| wr_valid | input | 1 | Byte write request |
| wr_ready | output | 1 | Holding register can take a byte |
| wr_data | input | DW | Data to send, LSB first |
| brk_req_set | input | 1 | Pulse: request one break frame |
| brk_req_clr | input | 1 | Pulse: withdraw a pending break request |
| brk_hold | input | 1 | Level: hold tx low while high |
| brk_req | output | 1 | One-shot break request bit |
| busy | output | 1 | Frame, break or guard in progress |
| tx_done | output | 1 | One-cycle pulse on return to idle |
| tx | output | 1 | Serial output, idles high |

## Verification
Data frames are swept over every 8-bit value and a strided set of 9-bit values, in all four combinations of word length and stop-bit count. This separates bit-order, length and stop-count faults. One-shot breaks are tried from idle in each configuration, behind a running character, with a cancel before the start, and with a repeated request both inside and after a break frame. These cases show whether the request is queued, cleared at the right time and protected against merging. A held break started in the middle of a data frame, with a second byte queued, shows whether the line is forced low, whether the guard lasts two ticks, and whether the queued byte survives.

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int DW          = 9,
  parameter int GUARD_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          cfg_nine,
  input  logic          cfg_two_stop,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          brk_req_set,
  input  logic          brk_req_clr,
  input  logic          brk_hold,
  output logic          brk_req,
  output logic          busy,
  output logic          tx_done,
  output logic          tx
);
  localparam int CW = $clog2(DW + GUARD_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_FRAME, S_STOP, S_HOLD, S_GUARD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, hold_d;
  logic          is_brk, req_q, hold_v, tx_q, done_q;

  logic [CW-1:0] nbits, last_stop;
  logic          in_brk_frame, finishing, launch, wr_fire;

  assign nbits        = cfg_nine ? CW'(DW) : CW'(DW - 1);
  assign last_stop    = CW'(cfg_two_stop);
  assign in_brk_frame = is_brk && (st == S_FRAME || st == S_STOP);
  assign finishing    = baud_tick &&
                        ((st == S_STOP  && cnt == last_stop) ||
                         (st == S_GUARD && cnt == CW'(GUARD_TICKS - 1)));
  assign launch       = !brk_hold && (req_q || hold_v) &&
                        (finishing || (baud_tick && st == S_IDLE));
  assign wr_ready     = !hold_v && !req_q && !brk_hold && !in_brk_frame &&
                        st != S_HOLD && st != S_GUARD;
  assign wr_fire      = wr_valid && wr_ready;

  assign brk_req = req_q;
  assign busy    = st != S_IDLE;
  assign tx_done = done_q;
  assign tx      = tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      hold_d <= '0;
      is_brk <= 1'b0;
      req_q  <= 1'b0;
      hold_v <= 1'b0;
      tx_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr_fire) begin
        hold_v <= 1'b1;
        hold_d <= wr_data;
      end
      if (brk_req_set && !in_brk_frame) req_q <= 1'b1;
      if (brk_req_clr) req_q <= 1'b0;

      if (brk_hold) begin
        st     <= S_HOLD;
        cnt    <= '0;
        tx_q   <= 1'b0;
        is_brk <= 1'b0;
      end else if (launch) begin
        st     <= S_FRAME;
        cnt    <= '0;
        tx_q   <= 1'b0;
        is_brk <= req_q;
        if (!req_q) begin
          sh     <= hold_d;
          hold_v <= 1'b0;
        end
      end else if (finishing) begin
        st     <= S_IDLE;
        cnt    <= '0;
        tx_q   <= 1'b1;
        done_q <= 1'b1;
      end else begin
        case (st)
          S_HOLD: begin
            st   <= S_GUARD;
            cnt  <= '0;
            tx_q <= 1'b1;
          end
          S_FRAME: if (baud_tick) begin
            if (cnt == nbits) begin
              st   <= S_STOP;
              cnt  <= '0;
              tx_q <= 1'b1;
              if (is_brk) req_q <= 1'b0;
            end else begin
              cnt  <= cnt + 1'b1;
              tx_q <= is_brk ? 1'b0 : sh[0];
              sh   <= sh >> 1;
            end
          end
          S_STOP, S_GUARD: if (baud_tick) cnt <= cnt + 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

module uart_brk_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic brk_hold,
  input logic brk_req,
  input logic brk_req_clr,
  input logic busy,
  input logic tx_done,
  input logic tx
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  p_clear_in_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(brk_req) && !$past(brk_req_clr)) |-> (tx && busy));
  p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hold |=> !tx);
  p_guard_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_hold) |=> (tx || brk_hold));
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!busy && tx));
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brk_hold(brk_hold), .brk_req(brk_req),
  .brk_req_clr(brk_req_clr), .busy(busy), .tx_done(tx_done), .tx(tx)
);

// File: tb/uart_brk_tx_test.sv
`timescale 1ns/1ps
module uart_brk_tx_test;
  logic clk = 0, rst_n = 0;
  logic cfg_nine = 0, cfg_two_stop = 0;
  logic wr_valid = 0;
  logic [8:0] wr_data = '0;
  logic brk_req_set = 0, brk_req_clr = 0, brk_hold = 0;
  logic wr_ready, brk_req, busy, tx_done, tx, baud_tick;
  logic [1:0] tc = '0;
  int tests = 0, fails = 0, cyc = 0, done_cnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tc <= tc + 1'b1;
  assign baud_tick = (tc == 2'd3);

  uart_brk_tx uut (.*);

  always @(negedge clk) if (tx_done) done_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic samp(output logic b);
    do @(negedge clk); while (!baud_tick);
    b = tx;
  endtask

  task automatic wait_start();
    logic b;
    do samp(b); while (b !== 1'b0);
  endtask

  task automatic get_bits(input int n, output logic [15:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < n; i++) begin samp(b); v[i] = b; end
  endtask

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pulse_set();
    brk_req_set = 1; @(negedge clk); brk_req_set = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] frame_exp(input logic [8:0] d, input int n, input int s);
    logic [15:0] e = '0;
    for (int i = 0; i < n; i++) e[i] = d[i];
    for (int i = 0; i < s; i++) e[n + i] = 1'b1;
    return e;
  endfunction

  initial begin
    logic [15:0] v, e;
    logic b;
    int n, s, ones;
    repeat (5) @(negedge clk);
    chk(tx === 1 && busy === 0 && tx_done === 0 && brk_req === 0 && wr_ready === 1,
        "R1 reset state", {tx, busy, tx_done, brk_req, wr_ready}, 5'b10001);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 sweep over word length, stop count and data
    for (int c = 0; c < 4; c++) begin
      cfg_nine = c[1]; cfg_two_stop = c[0];
      n = cfg_nine ? 9 : 8; s = cfg_two_stop ? 2 : 1;
      for (int d = 0; d < (cfg_nine ? 512 : 256); d += (cfg_nine ? 5 : 1)) begin
        send(9'(d));
        wait_start();
        get_bits(n + s, v);
        e = frame_exp(9'(d), n, s);
        chk(v == e, "R2 data frame", v, e);
        wait_idle();
      end
    end

    // R11 busy and single done pulse
    cfg_nine = 0; cfg_two_stop = 0;
    done_cnt = 0;
    send(9'h5A);
    wait_start();
    chk(busy === 1, "R11 busy in frame", busy, 1);
    wait_idle();
    chk(done_cnt == 1 && busy === 0, "R11 one done pulse", done_cnt, 1);

    // R3 break from idle in every configuration
    for (int c = 0; c < 4; c++) begin
      cfg_nine = c[1]; cfg_two_stop = c[0];
      n = cfg_nine ? 9 : 8; s = cfg_two_stop ? 2 : 1;
      @(negedge clk); pulse_set();
      wait_start();
      get_bits(n + s + 1, v);
      e = '0;
      for (int i = n; i < n + s + 1; i++) e[i] = 1'b1;
      chk(v == e, "R3 break frame", v, e);
      wait_idle();
    end

    // R5 hardware clear during stop bit
    cfg_nine = 0; cfg_two_stop = 0;
    @(negedge clk); pulse_set();
    while (brk_req) @(negedge clk);
    chk(tx === 1 && busy === 1, "R5 cleared in stop", {tx, busy}, 2'b11);
    wait_idle();

    // R4 break queued behind a running character
    send(9'h3C);
    while (tx) @(negedge clk);
    pulse_set();
    wait_start();
    get_bits(9, v);
    e = frame_exp(9'h3C, 8, 1);
    chk(v == e, "R4 data intact before break", v, e);
    get_bits(11, v);
    chk(v == 16'b0000_0110_0000_0000, "R4 break follows frame", v, 16'h0600);
    wait_idle();

    // R6 cancel before the break frame begins
    do @(negedge clk); while (!baud_tick);
    pulse_set();
    brk_req_clr = 1; @(negedge clk); brk_req_clr = 0;
    ones = 0;
    for (int i = 0; i < 30; i++) begin samp(b); if (b) ones++; end
    chk(ones == 30 && busy === 0 && brk_req === 0, "R6 cancelled break", ones, 30);

    // R7 request during a break is ignored, after it is honoured
    pulse_set();
    wait_start();
    get_bits(3, v);
    pulse_set();
    get_bits(6, v);
    ones = 0;
    for (int i = 0; i < 25; i++) begin samp(b); if (b) ones++; end
    chk(ones == 25 && brk_req === 0, "R7 no merged break", ones, 25);
    @(negedge clk); pulse_set();
    wait_start();
    get_bits(10, v);
    chk(v == 16'b0000_0011_0000_0000, "R7 later break sent", v, 16'h0300);
    wait_idle();

    // R8 R9 R10 held break over a running frame with a queued byte
    send(9'h11);
    while (tx) @(negedge clk);
    send(9'h0C3);
    @(negedge clk);
    brk_hold = 1;
    #1;
    chk(wr_ready === 0, "R10 ready low in hold", wr_ready, 0);
    ones = 0;
    for (int i = 0; i < 40; i++) begin samp(b); if (b) ones++; end
    chk(ones == 0 && busy === 1, "R8 line held low", ones, 0);
    chk(wr_ready === 0, "R10 ready low while held", wr_ready, 0);
    brk_hold = 0;
    ones = 0;
    samp(b);
    while (b) begin ones++; samp(b); end
    chk(ones == 2, "R9 guard length in ticks", ones, 2);
    get_bits(9, v);
    e = frame_exp(9'h0C3, 8, 1);
    chk(v == e, "R10 queued byte after guard", v, e);
    wait_idle();
    chk(tx === 1 && busy === 0 && wr_ready === 1, "R1 idle after all",
        {tx, busy, wr_ready}, 3'b101);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule